// File: doc/BRIEF.md
# Two-Way Set-Associative Translation Buffer

This block keeps the most recent page translations close to the load/store path. A lookup presents a virtual page number, 40 bits wide because a 52-bit virtual address is split over 4 KB pages. In the same cycle the block answers with a hit flag, the 20-bit physical page number that forms a 32-bit physical address, and four protection bits. The answer comes from combinational logic, so the lookup runs side by side with a cache tag read and adds no cycle. Storage is 64 entries: 32 sets, each with two ways. The five low bits of the page number select the set, and the remaining 35 bits form the tag.

On a miss the block does not walk any table. It latches the missing page number and raises a miss request on a valid/ready pair. Software then searches the page table and loads the translation through the write port. The miss request obeys the usual stream rules:
- `miss_vpn` stays stable while `miss_valid` is high and `miss_ready` is low.
- Misses that arrive while a request is stalled are dropped. The lookup still reports them as misses, and software retries them.
- A miss that arrives in the same cycle as an acknowledge replaces the request.

Supervisor software keeps the entries consistent with memory. It can clear one set, or clear every entry at once.

Top module: `tlb2w`

## Requirements
- R1: After reset no entry is valid, `miss_valid` is 0, and every set's victim is way 0.
- R2: While `lk_valid` is 1, `lk_hit`, `lk_ppn` and `lk_prot` reflect the entry whose valid bit is set and whose stored tag equals `lk_vpn[39:5]`, in set `lk_vpn[4:0]`, in the same cycle. While `lk_valid` is 0, `lk_hit` is 0. On a miss, `lk_ppn` and `lk_prot` are 0.
- R3: A write with `wr_way_fixed`=1 stores tag, page number and protection of `wr_vpn` in way `wr_way` of set `wr_vpn[4:0]`. The entry becomes valid from the next cycle, and the other way of that set is left unchanged.
- R4: Each set keeps a victim way. A hit on way w, or a write into way w, makes the other way the victim. When a hit and a write touch the same set in the same cycle, the write's update wins. A write with `wr_way_fixed`=0 goes to the victim way.
- R5: `inv_set_en` clears the valid bits of both ways in set `inv_set_idx` at the next edge and leaves the other sets unchanged. If a write to that same set arrives in the same cycle, the write is lost.
- R6: `flush_en` clears all 64 valid bits in one cycle, and it overrides a write in the same cycle.
- R7: A lookup miss with no request outstanding sets `miss_valid` and `miss_vpn` at the next edge. While `miss_ready` is 0, both hold, and further misses are ignored.
- R8: When `miss_valid` and `miss_ready` are both 1, the request clears at the next edge. If a lookup misses in that same cycle, its page number is captured instead and `miss_valid` stays 1.
- R9: If both ways of a set hold a valid matching tag, the lookup returns way 0's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 40 | Lookup virtual page number |
| lk_hit | output | 1 | Lookup hit (combinational) |
| lk_ppn | output | 20 | Translated physical page number |
| lk_prot | output | 4 | Protection bits of hit entry |
| wr_en | input | 1 | Software entry write |
| wr_vpn | input | 40 | Page number to store |
| wr_ppn | input | 20 | Physical page number to store |
| wr_prot | input | 4 | Protection bits to store |
| wr_way_fixed | input | 1 | 1: use `wr_way`; 0: use victim way |
| wr_way | input | 1 | Explicit target way |
| inv_set_en | input | 1 | Invalidate one set |
| inv_set_idx | input | 5 | Set to invalidate |
| flush_en | input | 1 | Invalidate every entry |
| miss_valid | output | 1 | Miss request pending |
| miss_ready | input | 1 | Software accepts miss request |
| miss_vpn | output | 40 | Page number that missed |

## Verification
Some behaviours are checked by assertions on every cycle:
- Flush leaves no valid bit behind.
- Set invalidation clears the indexed set, and an uncontested write sets its valid bit.
- A write moves the victim away from the way it filled.
- A stalled miss request holds its page number, and an acknowledge with no new miss retires the request.

Other behaviours show only in the bench's scenarios:
- The translated data returned for every set and way.
- The same-cycle hit path, and the way 0 priority when both ways match.
- Victim selection over a sequence of automatic writes.
- That sets next to an invalidated one survive.
- That writes lose against invalidation and flush.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_BITS   = 52;
  localparam int PA_BITS   = 32;
  localparam int PAGE_SHFT = 12;
  localparam int IDX_BITS  = 5;
  localparam int PROT_BITS = 4;

  typedef enum logic {
    WAY_0 = 1'b0,
    WAY_1 = 1'b1
  } way_e;
endpackage

// File: rtl/tlb_way_bank.sv
module tlb_way_bank #(
  parameter int SET_W  = 5,
  parameter int TAG_W  = 35,
  parameter int PPN_W  = 20,
  parameter int PROT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  rd_idx,
  input  logic [TAG_W-1:0]  rd_tag,
  output logic              rd_match,
  output logic [PPN_W-1:0]  rd_ppn,
  output logic [PROT_W-1:0] rd_prot,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [PPN_W-1:0]  wr_ppn,
  input  logic [PROT_W-1:0] wr_prot,
  input  logic              inv_en,
  input  logic [SET_W-1:0]  inv_idx,
  input  logic              flush
);
  localparam int SETS = 1 << SET_W;

  logic [SETS-1:0]   vld_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [PPN_W-1:0]  ppn_q  [SETS];
  logic [PROT_W-1:0] prot_q [SETS];

  // valid bits: flush beats invalidate beats write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (flush) begin
      vld_q <= '0;
    end else begin
      if (wr_en)  vld_q[wr_idx]  <= 1'b1;
      if (inv_en) vld_q[inv_idx] <= 1'b0;
    end
  end

  // payload storage carries no reset
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      ppn_q[wr_idx]  <= wr_ppn;
      prot_q[wr_idx] <= wr_prot;
    end
  end

  assign rd_match = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign rd_ppn   = ppn_q[rd_idx];
  assign rd_prot  = prot_q[rd_idx];

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld_q == '0)); // R6
  AST_SET_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && !flush) |=> !vld_q[$past(inv_idx)]); // R5
  AST_WRITE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush && !(inv_en && inv_idx == wr_idx)) |=> vld_q[$past(wr_idx)]); // R3
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int SET_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_en,
  input  logic [SET_W-1:0] hit_idx,
  input  logic             hit_way,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_idx,
  input  logic             wr_way,
  input  logic [SET_W-1:0] q_idx,
  output logic             q_way
);
  localparam int SETS = 1 << SET_W;

  logic [SETS-1:0] vic_q;

  // a write's update is applied last so it wins on a shared set
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vic_q <= '0;
    end else begin
      if (hit_en) vic_q[hit_idx] <= ~hit_way;
      if (wr_en)  vic_q[wr_idx]  <= ~wr_way;
    end
  end

  assign q_way = vic_q[q_idx];

  AST_VICTIM_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (vic_q[$past(wr_idx)] != $past(wr_way))); // R4
endmodule

// File: rtl/tlb_miss_hold.sv
module tlb_miss_hold #(
  parameter int VPN_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_in,
  input  logic [VPN_W-1:0] miss_vpn_in,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [VPN_W-1:0] req_vpn
);
  logic             vld_q;
  logic [VPN_W-1:0] vpn_q;
  logic             take;

  assign take = miss_in && (!vld_q || req_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      vpn_q <= '0;
    end else if (take) begin
      vld_q <= 1'b1;
      vpn_q <= miss_vpn_in;
    end else if (req_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign req_valid = vld_q;
  assign req_vpn   = vpn_q;

  AST_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !req_ready) |=> (vld_q && $stable(vpn_q))); // R7
  AST_MISS_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && req_ready && !miss_in) |=> !vld_q); // R8
endmodule

// File: rtl/tlb2w.sv
module tlb2w
  import tlb_pkg::*;
#(
  parameter int VA_W      = VA_BITS,
  parameter int PA_W      = PA_BITS,
  parameter int PAGE_BITS = PAGE_SHFT,
  parameter int SET_W     = IDX_BITS,
  parameter int PROT_W    = PROT_BITS,
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int PPN_W    = PA_W - PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_hit,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic [PROT_W-1:0] lk_prot,
  input  logic              wr_en,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [PPN_W-1:0]  wr_ppn,
  input  logic [PROT_W-1:0] wr_prot,
  input  logic              wr_way_fixed,
  input  logic              wr_way,
  input  logic              inv_set_en,
  input  logic [SET_W-1:0]  inv_set_idx,
  input  logic              flush_en,
  output logic              miss_valid,
  input  logic              miss_ready,
  output logic [VPN_W-1:0]  miss_vpn
);
  localparam int TAG_W = VPN_W - SET_W;
  localparam int WAYS  = 2;

  logic [SET_W-1:0]  lk_idx, wr_idx;
  logic [TAG_W-1:0]  lk_tag, wr_tag;
  logic [WAYS-1:0]   way_match;
  logic [PPN_W-1:0]  way_ppn  [WAYS];
  logic [PROT_W-1:0] way_prot [WAYS];
  logic              any_match, victim, wr_tgt;
  way_e              hit_way;

  assign lk_idx = lk_vpn[SET_W-1:0];
  assign lk_tag = lk_vpn[VPN_W-1:SET_W];
  assign wr_idx = wr_vpn[SET_W-1:0];
  assign wr_tag = wr_vpn[VPN_W-1:SET_W];
  assign wr_tgt = wr_way_fixed ? wr_way : victim;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic wr_this;
    assign wr_this = wr_en && (int'(wr_tgt) == w);
    tlb_way_bank #(
      .SET_W (SET_W),
      .TAG_W (TAG_W),
      .PPN_W (PPN_W),
      .PROT_W(PROT_W)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_idx  (lk_idx),
      .rd_tag  (lk_tag),
      .rd_match(way_match[w]),
      .rd_ppn  (way_ppn[w]),
      .rd_prot (way_prot[w]),
      .wr_en   (wr_this),
      .wr_idx  (wr_idx),
      .wr_tag  (wr_tag),
      .wr_ppn  (wr_ppn),
      .wr_prot (wr_prot),
      .inv_en  (inv_set_en),
      .inv_idx (inv_set_idx),
      .flush   (flush_en)
    );
  end

  // way 0 takes priority on a double match
  assign any_match = |way_match;
  assign hit_way   = way_match[0] ? WAY_0 : WAY_1;
  assign lk_hit    = lk_valid && any_match;
  assign lk_ppn    = lk_hit ? way_ppn[hit_way]  : '0;
  assign lk_prot   = lk_hit ? way_prot[hit_way] : '0;

  tlb_victim #(.SET_W(SET_W)) u_victim (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit_en (lk_hit),
    .hit_idx(lk_idx),
    .hit_way(hit_way),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_way (wr_tgt),
    .q_idx  (wr_idx),
    .q_way  (victim)
  );

  tlb_miss_hold #(.VPN_W(VPN_W)) u_miss (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_in    (lk_valid && !any_match),
    .miss_vpn_in(lk_vpn),
    .req_valid  (miss_valid),
    .req_ready  (miss_ready),
    .req_vpn    (miss_vpn)
  );
endmodule

// File: tb/sim_tlb2w.sv
module sim_tlb2w;
  localparam int VPN_W = 40;
  localparam int PPN_W = 20;
  localparam int SETS  = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             lk_valid = 1'b0;
  logic [VPN_W-1:0] lk_vpn = '0;
  logic             lk_hit;
  logic [PPN_W-1:0] lk_ppn;
  logic [3:0]       lk_prot;
  logic             wr_en = 1'b0;
  logic [VPN_W-1:0] wr_vpn = '0;
  logic [PPN_W-1:0] wr_ppn = '0;
  logic [3:0]       wr_prot = '0;
  logic             wr_way_fixed = 1'b0;
  logic             wr_way = 1'b0;
  logic             inv_set_en = 1'b0;
  logic [4:0]       inv_set_idx = '0;
  logic             flush_en = 1'b0;
  logic             miss_valid;
  logic             miss_ready = 1'b1;
  logic [VPN_W-1:0] miss_vpn;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  tlb2w u0 (.*);

  function automatic logic [VPN_W-1:0] mk(input int tag, input int set);
    return {35'(tag), 5'(set)};
  endfunction
  function automatic logic [PPN_W-1:0] pp(input int set, input int w);
    return PPN_W'(32'h400 + set * 3 + w * 1000);
  endfunction
  function automatic logic [3:0] pr(input int set, input int w);
    return 4'(set ^ (w * 5));
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p,
                    input logic [3:0] pt, input logic fixed, input logic w);
    @(negedge clk);
    wr_en = 1; wr_vpn = v; wr_ppn = p; wr_prot = pt; wr_way_fixed = fixed; wr_way = w;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic look(input string req, input logic [VPN_W-1:0] v, input logic eh,
                      input logic [PPN_W-1:0] ep, input logic [3:0] et);
    @(negedge clk);
    lk_valid = 1; lk_vpn = v;
    #2;
    chk(req, {63'd0, lk_hit}, {63'd0, eh});
    chk(req, {44'd0, lk_ppn}, {44'd0, (eh ? ep : 20'd0)});
    chk(req, {60'd0, lk_prot}, {60'd0, (eh ? et : 4'd0)});
    @(posedge clk); #1 lk_valid = 0;
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state
    chk("R1 miss_valid", {63'd0, miss_valid}, 64'd0);
    for (int s = 0; s < SETS; s++) look("R1 empty", mk(5, s), 0, 0, 0);
    // R1/R4: fresh set victim is way 0
    wr(mk(77, 20), 20'h11, 4'h1, 0, 0);
    wr(mk(78, 20), 20'h22, 4'h2, 1, 1);
    look("R4 reset victim", mk(77, 20), 1, 20'h11, 4'h1);
    // R3: fill every set and way explicitly
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < 2; w++)
        wr(mk(100 + s * 2 + w, s), pp(s, w), pr(s, w), 1, 1'(w));
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < 2; w++)
        look("R3 R2 fill", mk(100 + s * 2 + w, s), 1, pp(s, w), pr(s, w));
    // R2: no hit when idle
    @(negedge clk); lk_vpn = mk(100, 0); lk_valid = 0; #2;
    chk("R2 idle", {63'd0, lk_hit}, 64'd0);
    // R4: last hit on way 1 so victim is way 0, then way 1
    wr(mk(900, 3), 20'hAAAA, 4'hA, 0, 0);
    wr(mk(901, 3), 20'hBBBB, 4'hB, 0, 0);
    look("R4 auto0", mk(900, 3), 1, 20'hAAAA, 4'hA);
    look("R4 auto1", mk(901, 3), 1, 20'hBBBB, 4'hB);
    look("R4 evicted", mk(100 + 3 * 2 + 1, 3), 0, 0, 0);
    // R5: set invalidate
    @(negedge clk); inv_set_en = 1; inv_set_idx = 5;
    @(posedge clk); #1 inv_set_en = 0;
    look("R5 inv w0", mk(110, 5), 0, 0, 0);
    look("R5 inv w1", mk(111, 5), 0, 0, 0);
    look("R5 keep s4", mk(108, 4), 1, pp(4, 0), pr(4, 0));
    look("R5 keep s6", mk(113, 6), 1, pp(6, 1), pr(6, 1));
    @(negedge clk); inv_set_en = 1; inv_set_idx = 7;
    wr_en = 1; wr_vpn = mk(555, 7); wr_ppn = 20'h5; wr_prot = 4'h5; wr_way_fixed = 1; wr_way = 0;
    @(posedge clk); #1 inv_set_en = 0; wr_en = 0;
    look("R5 wr lost", mk(555, 7), 0, 0, 0);
    look("R5 old gone", mk(115, 7), 0, 0, 0);
    // R9: double match returns way 0
    wr(mk(321, 9), 20'h0F0F0, 4'h3, 1, 0);
    wr(mk(321, 9), 20'h0A0A0, 4'h6, 1, 1);
    look("R9 way0 wins", mk(321, 9), 1, 20'h0F0F0, 4'h3);
    // R7: miss hold under back-pressure
    @(negedge clk); miss_ready = 0;
    look("R7 miss a", mk(4000, 12), 0, 0, 0);
    chk("R7 valid", {63'd0, miss_valid}, 64'd1);
    chk("R7 vpn", {24'd0, miss_vpn}, {24'd0, mk(4000, 12)});
    look("R7 miss b", mk(4001, 13), 0, 0, 0);
    repeat (3) @(posedge clk);
    #1 chk("R7 held vpn", {24'd0, miss_vpn}, {24'd0, mk(4000, 12)});
    chk("R7 held valid", {63'd0, miss_valid}, 64'd1);
    // R8: acknowledge retires
    @(negedge clk); miss_ready = 1;
    @(posedge clk); #1 chk("R8 retire", {63'd0, miss_valid}, 64'd0);
    @(negedge clk); miss_ready = 0;
    look("R8 miss c", mk(4002, 14), 0, 0, 0);
    @(negedge clk); miss_ready = 1;
    look("R8 replace", mk(4003, 15), 0, 0, 0);
    chk("R8 valid", {63'd0, miss_valid}, 64'd1);
    chk("R8 vpn", {24'd0, miss_vpn}, {24'd0, mk(4003, 15)});
    // R6: flush clears all and beats a write
    @(negedge clk); flush_en = 1;
    wr_en = 1; wr_vpn = mk(777, 2); wr_ppn = 20'h7; wr_prot = 4'h7; wr_way_fixed = 1; wr_way = 1;
    @(posedge clk); #1 flush_en = 0; wr_en = 0;
    for (int s = 0; s < SETS; s++) begin
      look("R6 flushed w0", mk(100 + s * 2, s), 0, 0, 0);
      look("R6 flushed w1", mk(100 + s * 2 + 1, s), 0, 0, 0);
    end
    look("R6 wr lost", mk(777, 2), 0, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule